// File: doc/BRIEF.md
# Frame-Position Start-Offset Strobe Generator

This block follows the receive position inside a 10 ms radio frame with three nested counters: the word inside a basic frame, the basic frame inside a hyperframe, and the hyperframe inside the radio frame. The word counter moves on every clock where a word-valid enable is high. Each counter carries into the next one when it wraps. A radio-frame-start pulse returns all three counters to zero.

Software programs a 32-bit offset word. That word names the position at which the transmitting master places the antenna-carrier container block. The receiver learns where the container sits only from this offset. When a word is accepted at that position, the block raises a start strobe for one clock. The strobe tells the downstream mapping logic when to resynchronise. The three counter values also appear at the ports so that neighbouring blocks can share them.

Top module: `frame_pos_strobe`

## Requirements
- R1: While reset is low, and in the first cycle after it, all three counter outputs read 0 and the start strobe is low.
- R2: A clock edge with frame_start high sets all three counters to 0 on the next cycle. This has priority over word_valid.
- R3: A clock edge with word_valid high and frame_start low advances the word counter by one. After WORDS_PER_BF-1 the word counter returns to 0 and carries into the basic-frame counter.
- R4: The basic-frame counter wraps after BF_PER_HF-1 and carries into the hyperframe counter. The hyperframe counter wraps after HF_PER_FRAME-1, so the position also wraps with no frame_start.
- R5: A clock edge with word_valid low and frame_start low leaves all three counters unchanged.
- R6: The offset fields are: basic frame in bits [7:0], hyperframe in bits [15:8], word in bits [23:16]. Bits [31:24] are ignored. The strobe is high in the cycle after an edge that accepts a word whose counter values equal the three fields. For example, 0x00020001 fires for word 2, basic frame 1, hyperframe 0.
- R7: The strobe lasts exactly one cycle. With a constant offset and continuous words, it fires exactly once per pass through the frame.
- R8: If any offset field is at or above its counter's limit, the strobe never fires.
- R9: An edge with frame_start high never produces a strobe, even when the position matches and word_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | One received word is present this cycle |
| frame_start | input | 1 | Radio-frame boundary pulse; clears the position |
| offset_cfg | input | 32 | Programmed start position (see R6) |
| start_strobe | output | 1 | One-cycle pulse at the programmed position |
| hf_cnt | output | 8 | Current hyperframe number |
| bf_cnt | output | 8 | Current basic frame within the hyperframe |
| word_cnt | output | 8 | Current word within the basic frame |

## Verification
The hardest situation to reach is the hyperframe wrap, and the strobes that fall close to it. At the default sizes a full radio frame is more than 600,000 words, so the bench builds the block with small limits. It then drives several frames of continuous words with no frame_start, which crosses the hyperframe wrap. A long random phase then mixes gaps in word_valid, rare frame_start pulses (some arriving exactly on a matching word) and offsets drawn just inside and just outside the counter limits. Every cycle is compared against a position model kept in the bench.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] hf;
    logic [FIELD_W-1:0] bf;
    logic [FIELD_W-1:0] word;
  } frame_pos_t;

  // Unpack the programmed offset into a position (word[23:16], hf[15:8], bf[7:0]).
  function automatic frame_pos_t offset_to_pos(input logic [31:0] cfg);
    frame_pos_t p;
    p.word = cfg[23:16];
    p.hf   = cfg[15:8];
    p.bf   = cfg[7:0];
    return p;
  endfunction

  function automatic logic pos_equal(input frame_pos_t a, input frame_pos_t b);
    return (a.hf == b.hf) && (a.bf == b.bf) && (a.word == b.word);
  endfunction
endpackage

// File: rtl/fps_wrap_cnt.sv
module fps_wrap_cnt #(
  parameter int LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  output logic [7:0] cnt,
  output logic       wrap
);
  localparam logic [7:0] LAST = 8'(LIMIT - 1);

  assign wrap = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + 8'd1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);                      // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr |=> cnt == 8'd0);                // R2
  AST_CNT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (!clr && !step) |=> $stable(cnt));   // R5
endmodule

// File: rtl/fps_match.sv
module fps_match
  import fps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  input  logic        frame_start,
  input  logic [31:0] offset_cfg,
  input  frame_pos_t  cur_pos,
  output logic        strobe
);
  frame_pos_t target;
  logic       pos_hit;
  logic       unused_hi;

  assign target    = offset_to_pos(offset_cfg);
  assign unused_hi = ^offset_cfg[31:24];
  assign pos_hit   = pos_equal(cur_pos, target);

  always_ff @(posedge clk) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= word_valid && !frame_start && pos_hit;
  end

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(word_valid && !frame_start));                                       // R9
endmodule

// File: rtl/frame_pos_strobe.sv
module frame_pos_strobe
  import fps_pkg::*;
#(
  parameter int WORDS_PER_BF = 16,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_FRAME = 150
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  input  logic        frame_start,
  input  logic [31:0] offset_cfg,
  output logic        start_strobe,
  output logic [7:0]  hf_cnt,
  output logic [7:0]  bf_cnt,
  output logic [7:0]  word_cnt
);
  localparam int LEVELS = 3;

  function automatic int level_limit(input int lvl);
    return (lvl == 0) ? WORDS_PER_BF : (lvl == 1) ? BF_PER_HF : HF_PER_FRAME;
  endfunction

  logic [LEVELS:0]  carry;
  logic [7:0]       lvl_cnt [LEVELS];
  frame_pos_t       cur_pos;
  logic             frame_wrap;

  assign carry[0] = word_valid && !frame_start;

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    fps_wrap_cnt #(.LIMIT(level_limit(g))) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_start),
      .step  (carry[g]),
      .cnt   (lvl_cnt[g]),
      .wrap  (carry[g+1])
    );
  end

  assign frame_wrap = carry[LEVELS];
  assign word_cnt   = lvl_cnt[0];
  assign bf_cnt     = lvl_cnt[1];
  assign hf_cnt     = lvl_cnt[2];
  assign cur_pos    = '{hf: hf_cnt, bf: bf_cnt, word: word_cnt};

  fps_match u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .frame_start (frame_start),
    .offset_cfg  (offset_cfg),
    .cur_pos     (cur_pos),
    .strobe      (start_strobe)
  );

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |=> !start_strobe);                                                     // R7
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (hf_cnt == 8'd0 && bf_cnt == 8'd0 && word_cnt == 8'd0));              // R4
endmodule

// File: tb/frame_pos_strobe_tb.sv
module frame_pos_strobe_tb;
  localparam int NW = 4, NB = 8, NH = 5;
  localparam int FRAME = NW * NB * NH;

  logic clk = 1'b0, rst_n = 1'b0, word_valid = 1'b0, frame_start = 1'b0;
  logic [31:0] offset_cfg = '0;
  logic start_strobe;
  logic [7:0] hf_cnt, bf_cnt, word_cnt;

  int vectors = 0, miscompares = 0, strobe_seen = 0;
  int mw = 0, mb = 0, mh = 0;
  bit ms = 0, finished = 0;

  always #4 clk = ~clk;

  frame_pos_strobe #(.WORDS_PER_BF(NW), .BF_PER_HF(NB), .HF_PER_FRAME(NH)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .frame_start(frame_start),
    .offset_cfg(offset_cfg), .start_strobe(start_strobe),
    .hf_cnt(hf_cnt), .bf_cnt(bf_cnt), .word_cnt(word_cnt));

  function automatic bit exp_hit(int h, int b, int w, logic [31:0] off);
    return (int'(off[15:8]) == h) && (int'(off[7:0]) == b) && (int'(off[23:16]) == w);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string ctag, string stag);
    check(ctag, "word_cnt", int'(word_cnt), mw);
    check(ctag, "bf_cnt", int'(bf_cnt), mb);
    check(ctag, "hf_cnt", int'(hf_cnt), mh);
    check(stag, "start_strobe", int'(start_strobe), int'(ms));
    if (start_strobe) strobe_seen++;
  endtask

  // Called at a falling edge: drive inputs, predict the next rising edge, compare at the next falling edge.
  task automatic step(bit v, bit fs);
    string ctag, stag;
    word_valid = v; frame_start = fs;
    ctag = fs ? "R2" : (v ? "R3" : "R5");
    stag = fs ? "R9" : "R6";
    if (fs) begin
      mw = 0; mb = 0; mh = 0; ms = 0;
    end else if (v) begin
      ms = exp_hit(mh, mb, mw, offset_cfg);
      mw++;
      if (mw == NW) begin
        mw = 0; mb++;
        if (mb == NB) begin mb = 0; mh++; ctag = "R4"; if (mh == NH) mh = 0; end
      end
    end else ms = 0;
    @(negedge clk);
    compare_all(ctag, stag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run got 1 expired expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int first_at;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    compare_all("R1", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1", "R1");

    // R6: worked example, word 2 of basic frame 1 of hyperframe 0
    offset_cfg = 32'h0002_0001;
    step(0, 1);
    strobe_seen = 0; first_at = -1;
    for (int i = 1; i <= 2 * FRAME; i++) begin
      step(1, 0);
      if (start_strobe && first_at < 0) first_at = i;
    end
    check("R6", "steps to first strobe", first_at, NW + 2 + 1);
    check("R7", "strobes over two frames", strobe_seen, 2);

    // R8: offsets outside the counter ranges
    offset_cfg = 32'h0007_0000;
    step(0, 1); strobe_seen = 0;
    for (int i = 0; i < FRAME; i++) step(1, 0);
    check("R8", "strobes with word field out of range", strobe_seen, 0);
    offset_cfg = 32'hFF00_0900;
    step(0, 1); strobe_seen = 0;
    for (int i = 0; i < FRAME; i++) step(1, 0);
    check("R8", "strobes with hf field out of range", strobe_seen, 0);

    // R9: matching position at 0 while frame_start is held high
    offset_cfg = 32'hAB00_0000;
    strobe_seen = 0;
    for (int i = 0; i < 3; i++) step(1, 1);
    check("R9", "strobes during frame_start", strobe_seen, 0);
    step(1, 0);
    check("R6", "strobe at position 0, upper bits ignored", int'(start_strobe), 1);

    // Random mix, with offsets drawn near the limits
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 499) == 0)
        offset_cfg = {8'($urandom), 8'($urandom_range(0, NW)),
                      8'($urandom_range(0, NH)), 8'($urandom_range(0, NB))};
      step($urandom_range(0, 9) < 8, $urandom_range(0, 399) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule